// File: doc/BRIEF.md
# Iterative Multiply/Divide Engine

This block computes unsigned products, and unsigned quotients with remainders, for 8-bit and 16-bit operands. It works one bit per clock cycle: a shift-add loop for products and a restoring loop for quotients. A caller raises `start` while `busy` is low and presents the operands, the operation and the width. `busy` stays high while the loop runs. `done` pulses for one cycle when the outputs hold the new answer. The outputs keep that answer until the next completion.

The register forms return one packed result. A multiply returns a double-width product. A divide returns the quotient in the upper half of the double-width field and the remainder in the lower half. Two accumulator-style forms work on 8-bit operands only. They return their answer as a pair of bytes, in the way a paired accumulator and auxiliary register would receive it. The latency is 8 cycles for any 8-bit operation and 16 cycles for a 16-bit operation.

Top module: `muldiv_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next state has `busy`, `done` and `ovf` low and `result`, `acc_lo` and `acc_hi` at zero.
- R2: A `start` sampled high while `busy` is low begins an operation, and `busy` is high from the next cycle. `done` is high for exactly one cycle, 1+N cycles after the accepting edge, where N is 16 for a 16-bit multiply or divide and 8 otherwise. `busy` is low in the `done` cycle.
- R3: `start` and all operand and operation inputs sampled while `busy` is high have no effect on the running operation or its result.
- R4: `op` = 0 with `wide` = 0 (8-bit multiply) gives `result[15:0]` = a×b and `result[31:16]` = 0.
- R5: `op` = 0 with `wide` = 1 (16-bit multiply) gives the full 32-bit product in `result`.
- R6: For `op` = 0 and `op` = 3, `ovf` is 1 exactly when the upper half of the product (bits 15:8 for 8-bit, bits 31:16 for 16-bit) is nonzero.
- R7: `op` = 1 with `wide` = 0 (8-bit divide) gives the quotient in `result[15:8]`, the remainder in `result[7:0]`, zero in `result[31:16]`, and `ovf` = 0 for a nonzero divisor.
- R8: `op` = 1 with `wide` = 1 (16-bit divide) gives the quotient in `result[31:16]`, the remainder in `result[15:0]`, and `ovf` = 0 for a nonzero divisor.
- R9: `op` = 3 (accumulator multiply, always 8-bit) drives `acc_hi` with product bits 15:8, `acc_lo` with bits 7:0, and `result` with the 16-bit product.
- R10: `op` = 2 (accumulator divide, always 8-bit) drives the quotient on `acc_lo` and the remainder on `acc_hi`, and `result` as in R7.
- R11: A divide (`op` 1 or 2) by a zero divisor sets `ovf` to 1. The quotient and remainder fields are driven to all ones within the operation's width (`result` = 32'h0000FFFF for 8-bit, 32'hFFFFFFFF for 16-bit, and `acc_lo` = `acc_hi` = 8'hFF for `op` 2). `done` still comes with the normal latency.
- R12: `result`, `acc_lo`, `acc_hi` and `ovf` change only in the cycle `done` goes high and hold otherwise. `acc_lo` and `acc_hi` are zero after `op` 0 or 1.
- R13: In 8-bit operations, bits 15:8 of `opa` and `opb` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin an operation |
| op | input | 2 | 0 multiply, 1 divide, 2 accumulator divide, 3 accumulator multiply |
| wide | input | 1 | 1 selects 16-bit operands for op 0 and 1 |
| opa | input | 16 | Multiplicand or dividend |
| opb | input | 16 | Multiplier or divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Packed product or quotient:remainder |
| acc_lo | output | 8 | Accumulator-form low byte / quotient |
| acc_hi | output | 8 | Accumulator-form high byte / remainder |
| ovf | output | 1 | Product overflow or divide by zero |

## Verification
Operands of 0, 1 and the width's maximum are applied in every operation and width. These expose any loss of the top multiplier or dividend bit, any fault in the restoring compare at its limits, and the zero-divisor path. Random operands then test the shift-add and restoring loops across many carry and borrow patterns, in both widths. Byte operations with garbage in the upper operand bits show whether the width masking is correct. Further runs change the operands and pulse `start` while the unit is busy. Still others hold the inputs idle after completion. Together these tell a loop that latches its inputs once from one that keeps sampling them.

// File: rtl/muldiv_pkg.sv
// Shared definitions for the multiply/divide engine.
// Assumes: the operation code is carried on a 2-bit port.
package muldiv_pkg;

    typedef enum logic [1:0] {
        OP_MUL    = 2'd0,
        OP_DIV    = 2'd1,
        OP_DIV_AB = 2'd2,
        OP_MUL_AB = 2'd3
    } md_op_e;

endpackage

// File: rtl/md_seq.sv
// Step sequencer: accepts a start while idle, counts the loop steps,
// and emits a one-cycle done after the final step.
// Assumes: LONG_STEPS >= SHORT_STEPS >= 2.
module md_seq #(
    parameter int LONG_STEPS  = 16,
    parameter int SHORT_STEPS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic long_op,
    output logic busy,
    output logic load,
    output logic step,
    output logic last,
    output logic done
);
    localparam int CW = $clog2(LONG_STEPS + 1);
    localparam logic [CW-1:0] N_LONG  = CW'(LONG_STEPS);
    localparam logic [CW-1:0] N_SHORT = CW'(SHORT_STEPS);

    logic [CW-1:0] cnt;

    // Accept only while idle; the loop steps on every busy cycle.
    always_comb begin
        load = start && !busy;
        step = busy;
        last = busy && (cnt == CW'(1));
    end

    // Count remaining steps and produce the busy level and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= last;
            if (load) begin
                busy <= 1'b1;
                cnt  <= long_op ? N_LONG : N_SHORT;
            end else if (busy) begin
                cnt <= cnt - CW'(1);
                if (last) busy <= 1'b0;
            end
        end
    end

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> (busy && !done));

endmodule

// File: rtl/md_mul.sv
// Shift-add multiplier: scans the multiplier from its top active bit,
// doubling the accumulator and adding the multiplicand on each 1 bit.
// Assumes: 8-bit operands are aligned so their MSB sits at bit DW-1.
module md_mul #(
    parameter int DW = 16,
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic            short_op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [2*DW-1:0] prod_nxt
);
    localparam int PW = 2 * DW;

    logic [PW-1:0] acc;
    logic [DW-1:0] mcand;
    logic [DW-1:0] mplier;

    // Next partial product: shift left, add multiplicand on a set bit.
    always_comb begin
        prod_nxt = {acc[PW-2:0], 1'b0}
                 + (mplier[DW-1] ? {{DW{1'b0}}, mcand} : {PW{1'b0}});
    end

    // Load aligned operands, then advance one multiplier bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            mcand  <= '0;
            mplier <= '0;
        end else if (load) begin
            acc    <= '0;
            mcand  <= short_op ? {{(DW-BW){1'b0}}, a[BW-1:0]} : a;
            mplier <= short_op ? {b[BW-1:0], {(DW-BW){1'b0}}} : b;
        end else if (step) begin
            acc    <= prod_nxt;
            mplier <= {mplier[DW-2:0], 1'b0};
        end
    end

    a_r4_acc_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mcand == '0) |=> (acc == '0));

endmodule

// File: rtl/md_div.sv
// Restoring divider: brings one dividend bit into the partial remainder
// per step, subtracts the divisor when it fits and records the bit.
// Assumes: 8-bit dividends are aligned so their MSB sits at bit DW-1.
module md_div #(
    parameter int DW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          short_op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] quo_nxt,
    output logic [DW-1:0] rem_nxt
);
    logic [DW-1:0] rem;
    logic [DW-1:0] quo;
    logic [DW-1:0] dvd;
    logic [DW-1:0] dvs;
    logic [DW:0]   shifted;
    logic [DW+1:0] diff;
    logic          fits;

    // Trial subtraction of the divisor from the shifted remainder.
    always_comb begin
        shifted = {rem, dvd[DW-1]};
        diff    = {1'b0, shifted} - {2'b00, dvs};
        fits    = !diff[DW+1];
        rem_nxt = fits ? diff[DW-1:0] : shifted[DW-1:0];
        quo_nxt = {quo[DW-2:0], fits};
    end

    // Load aligned operands, then perform one restoring step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
            quo <= '0;
            dvd <= '0;
            dvs <= '0;
        end else if (load) begin
            rem <= '0;
            quo <= '0;
            dvd <= short_op ? {a[BW-1:0], {(DW-BW){1'b0}}} : a;
            dvs <= short_op ? {{(DW-BW){1'b0}}, b[BW-1:0]} : b;
        end else if (step) begin
            rem <= rem_nxt;
            quo <= quo_nxt;
            dvd <= {dvd[DW-2:0], 1'b0};
        end
    end

    a_r8_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (dvs != '0) |-> (rem < dvs));

endmodule

// File: rtl/muldiv_unit.sv
// Top of the multiply/divide engine: selects the width, runs the
// sequencer and both loops, and formats the final outputs on the last step.
// Assumes: DW = 2*BW; accumulator forms always use BW-bit operands.
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int DW = 16,
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      op,
    input  logic            wide,
    input  logic [DW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    output logic            busy,
    output logic            done,
    output logic [2*DW-1:0] result,
    output logic [BW-1:0]   acc_lo,
    output logic [BW-1:0]   acc_hi,
    output logic            ovf
);
    localparam int PW = 2 * DW;

    md_op_e          op_in;
    md_op_e          op_q;
    logic            long_in;
    logic            long_q;
    logic            divz_q;
    logic            load;
    logic            step;
    logic            last;
    logic [PW-1:0]   prod_nxt;
    logic [DW-1:0]   quo_nxt;
    logic [DW-1:0]   rem_nxt;
    logic [PW-1:0]   fin_res;
    logic [BW-1:0]   fin_lo;
    logic [BW-1:0]   fin_hi;
    logic            fin_ovf;

    // Decode the request: only the register forms may select 16 bits.
    always_comb begin
        op_in   = md_op_e'(op);
        long_in = wide && (op_in == OP_MUL || op_in == OP_DIV);
    end

    md_seq #(.LONG_STEPS(DW), .SHORT_STEPS(BW)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .long_op (long_in),
        .busy    (busy),
        .load    (load),
        .step    (step),
        .last    (last),
        .done    (done)
    );

    md_mul #(.DW(DW), .BW(BW)) u_mul (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .short_op (!long_in),
        .a        (opa),
        .b        (opb),
        .prod_nxt (prod_nxt)
    );

    md_div #(.DW(DW), .BW(BW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .short_op (!long_in),
        .a        (opa),
        .b        (opb),
        .quo_nxt  (quo_nxt),
        .rem_nxt  (rem_nxt)
    );

    // Capture the operation, width and zero-divisor flag at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_MUL;
            long_q <= 1'b0;
            divz_q <= 1'b0;
        end else if (load) begin
            op_q   <= op_in;
            long_q <= long_in;
            divz_q <= long_in ? (opb == '0) : (opb[BW-1:0] == '0);
        end
    end

    // Format the outputs from the final loop step.
    always_comb begin
        fin_res = '0;
        fin_lo  = '0;
        fin_hi  = '0;
        fin_ovf = 1'b0;
        case (op_q)
            OP_MUL, OP_MUL_AB: begin
                if (long_q) begin
                    fin_res = prod_nxt;
                    fin_ovf = (prod_nxt[PW-1:DW] != '0);
                end else begin
                    fin_res = {{DW{1'b0}}, prod_nxt[DW-1:0]};
                    fin_ovf = (prod_nxt[DW-1:BW] != '0);
                end
                if (op_q == OP_MUL_AB) begin
                    fin_lo = prod_nxt[BW-1:0];
                    fin_hi = prod_nxt[DW-1:BW];
                end
            end
            default: begin
                if (divz_q) begin
                    fin_ovf = 1'b1;
                    fin_res = long_q ? {PW{1'b1}} : {{DW{1'b0}}, {DW{1'b1}}};
                end else if (long_q) begin
                    fin_res = {quo_nxt, rem_nxt};
                end else begin
                    fin_res = {{DW{1'b0}}, quo_nxt[BW-1:0], rem_nxt[BW-1:0]};
                end
                if (op_q == OP_DIV_AB) begin
                    fin_lo = divz_q ? {BW{1'b1}} : quo_nxt[BW-1:0];
                    fin_hi = divz_q ? {BW{1'b1}} : rem_nxt[BW-1:0];
                end
            end
        endcase
    end

    // Output registers update only on the final step and hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            acc_lo <= '0;
            acc_hi <= '0;
            ovf    <= 1'b0;
        end else if (last) begin
            result <= fin_res;
            acc_lo <= fin_lo;
            acc_hi <= fin_hi;
            ovf    <= fin_ovf;
        end
    end

    a_r12_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(ovf) && $stable(acc_lo)));
    a_r6_no_ovf_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ovf && long_q && op_q == OP_MUL) |-> (result[PW-1:DW] == '0));
    a_r11_divz_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (done && divz_q && (op_q == OP_DIV || op_q == OP_DIV_AB)) |-> (ovf && result[BW-1:0] == '1));
    a_r7_short_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !long_q) |-> (result[PW-1:DW] == '0));

endmodule

// File: tb/muldiv_unit_tb.sv
// Scoreboard bench: a driver task queues the model's expected answer for
// each request; a monitor pops and compares it when done pulses.
module muldiv_unit_tb;

    typedef struct {
        logic [31:0] res;
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic        ovf;
        int          due;
        string       tag;
        string       ftag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic        wide = 1'b0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic        busy;
    logic        done;
    logic [31:0] result;
    logic [7:0]  acc_lo;
    logic [7:0]  acc_hi;
    logic        ovf;

    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;
    exp_t sb[$];
    exp_t last_exp;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    muldiv_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
        .opa(opa), .opb(opb), .busy(busy), .done(done), .result(result),
        .acc_lo(acc_lo), .acc_hi(acc_hi), .ovf(ovf)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [1:0] o, input logic w,
                                   input logic [15:0] a, input logic [15:0] b);
        exp_t e;
        logic        lng;
        logic [31:0] aa, bb, p, q, r;
        lng = w && (o == 2'd0 || o == 2'd1);
        aa = lng ? {16'h0, a} : {24'h0, a[7:0]};
        bb = lng ? {16'h0, b} : {24'h0, b[7:0]};
        e.lo = '0; e.hi = '0; e.ovf = 1'b0;
        if (o == 2'd0 || o == 2'd3) begin
            p = aa * bb;
            e.res = p;
            e.ovf = lng ? (p[31:16] != 0) : (p[15:8] != 0);
            if (o == 2'd3) begin e.lo = p[7:0]; e.hi = p[15:8]; end
            e.ftag = "R6";
        end else begin
            e.ftag = "R11";
            if (bb == 0) begin
                e.ovf = 1'b1;
                e.res = lng ? 32'hFFFF_FFFF : 32'h0000_FFFF;
                if (o == 2'd2) begin e.lo = 8'hFF; e.hi = 8'hFF; end
            end else begin
                q = aa / bb;
                r = aa % bb;
                e.res = lng ? {q[15:0], r[15:0]} : {16'h0, q[7:0], r[7:0]};
                if (o == 2'd2) begin e.lo = q[7:0]; e.hi = r[7:0]; end
            end
        end
        e.due = lng ? 16 : 8;
        return e;
    endfunction

    function automatic string op_tag(input logic [1:0] o, input logic w);
        case (o)
            2'd0: return w ? "R5" : "R4";
            2'd1: return w ? "R8" : "R7";
            2'd2: return "R10";
            default: return "R9";
        endcase
    endfunction

    // Driver: issue one request at a negedge, optionally disturb while busy.
    task automatic run(input logic [1:0] o, input logic w, input logic [15:0] a,
                       input logic [15:0] b, input bit disturb, input string tag);
        exp_t e;
        e = model(o, w, a, b);
        e.due = cyc + 1 + e.due;
        e.tag = (tag == "") ? op_tag(o, w) : tag;
        if (o == 2'd1 && ((w && b == 0) || (!w && b[7:0] == 0))) e.tag = "R11";
        if (o == 2'd2 && b[7:0] == 0) e.tag = "R11";
        sb.push_back(e);
        op = o; wide = w; opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            start = 1'b1; op = ~o; wide = ~w; opa = ~a; opb = b ^ 16'h5A5A;
            @(negedge clk);
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        last_exp = e;
        @(negedge clk);
    endtask

    // Monitor: compare each completion against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", "unexpected done", {31'b0, done}, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(result === e.res, e.tag, "result", result, e.res);
                check(acc_lo === e.lo && acc_hi === e.hi,
                      (e.tag == "R9" || e.tag == "R10") ? e.tag : "R12",
                      "acc_hi:acc_lo", {16'h0, acc_hi, acc_lo}, {16'h0, e.hi, e.lo});
                check(ovf === e.ovf, e.ftag, "ovf", {31'b0, ovf}, {31'b0, e.ovf});
                check(cyc == e.due && !busy, "R2", "done cycle", cyc, e.due);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R2 watchdog actual=hung expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] corner [3];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy && !done && !ovf, "R1", "flags", {29'b0, busy, done, ovf}, 32'h0);
        check(result == 0 && acc_lo == 0 && acc_hi == 0, "R1", "outputs",
              result | {16'h0, acc_hi, acc_lo}, 32'h0);

        // Corners 0, 1, max in every operation and width
        for (int o = 0; o < 4; o++) begin
            for (int w = 0; w < 2; w++) begin
                corner[0] = 16'h0;
                corner[1] = 16'h1;
                corner[2] = w ? 16'hFFFF : 16'h00FF;
                for (int i = 0; i < 3; i++)
                    for (int j = 0; j < 3; j++)
                        run(o[1:0], w[0], corner[i], corner[j], 1'b0, "");
            end
        end

        // Random operands per operation and width
        for (int o = 0; o < 4; o++)
            for (int w = 0; w < 2; w++)
                for (int k = 0; k < 25; k++)
                    run(o[1:0], w[0], 16'($urandom), 16'($urandom), 1'b0, "");

        // R13: garbage in the upper operand bits of 8-bit operations
        for (int k = 0; k < 12; k++)
            run(2'(k % 4), 1'b0, 16'($urandom) | 16'hA500, 16'($urandom) | 16'h5A00,
                1'b0, (k % 4 == 1 || k % 4 == 0) ? "R13" : "");

        // R3: start and inputs toggled while busy
        for (int k = 0; k < 12; k++)
            run(2'(k % 4), k[2], 16'($urandom), 16'($urandom) | 16'h0101, 1'b1, "R3");

        // R12: outputs hold while idle inputs change
        for (int k = 0; k < 4; k++) begin
            run(2'(k), 1'b1, 16'($urandom), 16'($urandom), 1'b0, "");
            opa = 16'($urandom); opb = 16'($urandom); op = 2'(~k);
            repeat (3) @(negedge clk);
            check(result === last_exp.res && ovf === last_exp.ovf &&
                  acc_lo === last_exp.lo && acc_hi === last_exp.hi,
                  "R12", "held result", result, last_exp.res);
        end

        repeat (2) @(negedge clk);
        check(sb.size() == 0, "R2", "pending items", sb.size(), 32'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule